// File: doc/BRIEF.md
# Colour Channel Gain/Offset Rotation Sequencer

This block chooses which colour channel (red, green or blue) a three-input sensor front end is working on at each pixel. It decides which input the analog path samples and which channel's gain and offset settings drive the programmable gain stage and the offset DAC. The gain and offset values come from a register bank as three 6-bit gains and three 8-bit offsets. The block sends the selected pair to the signal chain, together with the channel indices and a strobe that triggers simultaneous sampling of all three inputs.

A 2-bit configuration picks one of four schemes:
- one fixed red channel;
- a single red input whose gain and offset rotate pixel by pixel;
- three inputs whose selection, gain and offset rotate together pixel by pixel;
- three inputs that rotate once per scan line.

The line-sync input marks line starts. In the per-pixel schemes it holds the rotation at red. In the per-line scheme its falling edge steps the rotation. A mode-register write strobe restarts the per-line rotation at red.

The block runs on a single clock. Each rising edge of that clock stands for one pixel-clock event at which the channel may change. The line-sync input is sampled on the same clock. The external timing rule is that line sync rises no earlier than a pixel clock edge, so a sampled view of it is exact.

Top module: `chan_rot_seq`

## Requirements
- R1: While reset is held, `par_sel` and `in_sel` are red (code 0), `gain_out` and `ofs_out` are 0 and `sample_stb` is low. Channel codes are red=0, green=1, blue=2 on every channel port.
- R2: With `cfg`=00, each clock edge sets `par_sel` and `in_sel` to red and loads `gain_out`/`ofs_out` from the red registers.
- R3: With `cfg`=01, `in_sel` stays red while `par_sel` steps red, green, blue, red on successive edges. `gain_out`/`ofs_out` carry the registers of the channel in `par_sel`.
- R4: With `cfg`=10, `in_sel` and `par_sel` step together red, green, blue, red on successive edges. `gain_out`/`ofs_out` follow the same channel.
- R5: In `cfg` 01 and 10, an edge that samples `line_sync` high sets the channel to red. The first edge that samples it low again also gives red, and each later edge advances one step.
- R6: `sample_stb` is high for exactly the cycles after an edge, in `cfg`=10 with `line_sync` low, that selected red, so it pulses every third pixel starting with red. In every other configuration, and while `line_sync` is high, it stays low.
- R7: With `cfg`=11, the channel advances one step (blue wraps to red) at the first edge that samples `line_sync` low after sampling it high. A high level of `line_sync` on its own does not move the channel.
- R8: With `cfg`=11, an edge with `mode_wr` high selects red. This takes priority over a simultaneous line-sync fall.
- R9: With `cfg`=11, between updates `par_sel`, `in_sel`, `gain_out` and `ofs_out` hold their values even if the register inputs change.
- R10: `gain_out`/`ofs_out` are registered and take the register values present at the edge that loads the new channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock; each rising edge is one pixel event |
| rst_n | input | 1 | Synchronous active-low reset |
| line_sync | input | 1 | Line-start marker (high during the line gap) |
| cfg | input | 2 | Rotation scheme: 00 fixed red, 01 rotate gain/offset, 10 rotate all per pixel, 11 rotate all per line |
| mode_wr | input | 1 | One-cycle strobe of a mode-register write |
| gain_red | input | GAIN_W | Red channel gain register |
| gain_grn | input | GAIN_W | Green channel gain register |
| gain_blu | input | GAIN_W | Blue channel gain register |
| ofs_red | input | OFS_W | Red channel offset register |
| ofs_grn | input | OFS_W | Green channel offset register |
| ofs_blu | input | OFS_W | Blue channel offset register |
| in_sel | output | 2 | Input channel to sample |
| par_sel | output | 2 | Channel whose gain/offset are applied |
| gain_out | output | GAIN_W | Selected gain |
| ofs_out | output | OFS_W | Selected offset |
| sample_stb | output | 1 | Simultaneous three-channel sample strobe |

## Verification
Suppose the rotation state is wrong, for example a missed step, a wrap to the unused code 3, or a stale line-sync history. In the per-pixel schemes this shows on `par_sel` and on the gain/offset values at the very next edge, and the bench compares every edge of a line against the pixel count modulo three. In the per-line scheme the error stays hidden until the next line-sync fall or mode write. For that reason the bench steps through several whole lines and checks that the outputs stay frozen between them. A strobe generated off-phase appears within three edges as a pulse on a non-red pixel.

// File: rtl/chan_rot_pkg.sv
// Shared channel codes, configuration codes and the rotation step function
// for the colour rotation sequencer. Assumes exactly three colour channels.
package chan_rot_pkg;

    localparam int NCH    = 3;
    localparam int CHAN_W = $clog2(NCH);

    typedef logic [CHAN_W-1:0] chan_t;

    localparam chan_t CH_RED = 2'd0;
    localparam chan_t CH_GRN = 2'd1;
    localparam chan_t CH_BLU = 2'd2;

    localparam logic [1:0] CFG_MONO    = 2'b00;
    localparam logic [1:0] CFG_PIX_PAR = 2'b01;
    localparam logic [1:0] CFG_PIX_ALL = 2'b10;
    localparam logic [1:0] CFG_LINE    = 2'b11;

    // Next channel in the red -> green -> blue -> red order.
    function automatic chan_t chan_next(input chan_t c);
        return (c == CH_BLU) ? CH_RED : chan_t'(c + chan_t'(1));
    endfunction

endpackage

// File: rtl/chan_rot_sync.sv
// Line-sync history tracker: remembers the previously sampled level of the
// line-sync input and flags the first edge at which it is seen low again.
// Assumes line_sync is already synchronous to clk.
module chan_rot_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_sync,
    output logic sync_fall
);

    logic prev_q;

    // Keep the level sampled at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= line_sync;
    end

    assign sync_fall = prev_q & ~line_sync;

endmodule

// File: rtl/chan_rot_ctrl.sv
// Rotation controller: holds the current rotation channel and decides, per
// configuration, whether this edge loads a new channel and which one.
// Also produces the simultaneous-sample strobe for the per-pixel
// three-input scheme.
module chan_rot_ctrl
    import chan_rot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg,
    input  logic       line_sync,
    input  logic       sync_fall,
    input  logic       mode_wr,
    output chan_t      chan_nxt,
    output logic       load,
    output logic       stb_q
);

    chan_t chan_q;

    // Choose the next channel and whether this edge updates it.
    always_comb begin
        load     = 1'b1;
        chan_nxt = CH_RED;
        case (cfg)
            CFG_MONO: chan_nxt = CH_RED;
            CFG_PIX_PAR, CFG_PIX_ALL: begin
                if (line_sync || sync_fall) chan_nxt = CH_RED;
                else                        chan_nxt = chan_next(chan_q);
            end
            default: begin
                if (mode_wr)        chan_nxt = CH_RED;
                else if (sync_fall) chan_nxt = chan_next(chan_q);
                else begin
                    load     = 1'b0;
                    chan_nxt = chan_q;
                end
            end
        endcase
    end

    // Rotation state register.
    always_ff @(posedge clk) begin
        if (!rst_n)    chan_q <= CH_RED;
        else if (load) chan_q <= chan_nxt;
    end

    // Strobe on every red pixel of the per-pixel three-input scheme.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= (cfg == CFG_PIX_ALL) && !line_sync && (chan_nxt == CH_RED);
    end

endmodule

// File: rtl/chan_rot_sel.sv
// Output selector: on each load picks the gain and offset of the next channel
// from the register bank and registers them with the two channel indices.
// Assumes load is asserted only at a channel update.
module chan_rot_sel
    import chan_rot_pkg::*;
#(
    parameter int GAIN_W = 6,
    parameter int OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg,
    input  logic              load,
    input  chan_t             chan_nxt,
    input  logic [GAIN_W-1:0] gain_red,
    input  logic [GAIN_W-1:0] gain_grn,
    input  logic [GAIN_W-1:0] gain_blu,
    input  logic [OFS_W-1:0]  ofs_red,
    input  logic [OFS_W-1:0]  ofs_grn,
    input  logic [OFS_W-1:0]  ofs_blu,
    output chan_t             in_sel,
    output chan_t             par_sel,
    output logic [GAIN_W-1:0] gain_out,
    output logic [OFS_W-1:0]  ofs_out
);

    logic [GAIN_W-1:0] gain_pick;
    logic [OFS_W-1:0]  ofs_pick;
    logic              multi_in;

    // Pick the register pair of the channel about to be loaded.
    always_comb begin
        case (chan_nxt)
            CH_GRN: begin gain_pick = gain_grn; ofs_pick = ofs_grn; end
            CH_BLU: begin gain_pick = gain_blu; ofs_pick = ofs_blu; end
            default: begin gain_pick = gain_red; ofs_pick = ofs_red; end
        endcase
    end

    assign multi_in = (cfg == CFG_PIX_ALL) || (cfg == CFG_LINE);

    // Register indices and settings together at each channel update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sel   <= CH_RED;
            par_sel  <= CH_RED;
            gain_out <= '0;
            ofs_out  <= '0;
        end else if (load) begin
            in_sel   <= multi_in ? chan_nxt : CH_RED;
            par_sel  <= chan_nxt;
            gain_out <= gain_pick;
            ofs_out  <= ofs_pick;
        end
    end

endmodule

// File: rtl/chan_rot_seq.sv
// Colour channel gain/offset rotation sequencer top. Connects the line-sync
// tracker, the rotation controller and the output selector. Assumes line_sync
// and mode_wr are synchronous to clk; mode_wr is a one-cycle strobe that
// coincides with the configuration value being written.
module chan_rot_seq
    import chan_rot_pkg::*;
#(
    parameter int GAIN_W = 6,
    parameter int OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_sync,
    input  logic [1:0]        cfg,
    input  logic              mode_wr,
    input  logic [GAIN_W-1:0] gain_red,
    input  logic [GAIN_W-1:0] gain_grn,
    input  logic [GAIN_W-1:0] gain_blu,
    input  logic [OFS_W-1:0]  ofs_red,
    input  logic [OFS_W-1:0]  ofs_grn,
    input  logic [OFS_W-1:0]  ofs_blu,
    output logic [1:0]        in_sel,
    output logic [1:0]        par_sel,
    output logic [GAIN_W-1:0] gain_out,
    output logic [OFS_W-1:0]  ofs_out,
    output logic              sample_stb
);

    logic  sync_fall;
    logic  load;
    chan_t chan_nxt;

    chan_rot_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_sync (line_sync),
        .sync_fall (sync_fall)
    );

    chan_rot_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .line_sync (line_sync),
        .sync_fall (sync_fall),
        .mode_wr   (mode_wr),
        .chan_nxt  (chan_nxt),
        .load      (load),
        .stb_q     (sample_stb)
    );

    chan_rot_sel #(
        .GAIN_W (GAIN_W),
        .OFS_W  (OFS_W)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .load     (load),
        .chan_nxt (chan_nxt),
        .gain_red (gain_red),
        .gain_grn (gain_grn),
        .gain_blu (gain_blu),
        .ofs_red  (ofs_red),
        .ofs_grn  (ofs_grn),
        .ofs_blu  (ofs_blu),
        .in_sel   (in_sel),
        .par_sel  (par_sel),
        .gain_out (gain_out),
        .ofs_out  (ofs_out)
    );

endmodule

// File: rtl/chan_rot_seq_chk.sv
// Property checker for the rotation sequencer, bound to the top module.
// Keeps its own copy of the line-sync history to judge line starts.
module chan_rot_seq_chk
    import chan_rot_pkg::*;
#(
    parameter int GAIN_W = 6,
    parameter int OFS_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_sync,
    input logic [1:0]        cfg,
    input logic              mode_wr,
    input logic [1:0]        in_sel,
    input logic [1:0]        par_sel,
    input logic [GAIN_W-1:0] gain_out,
    input logic [OFS_W-1:0]  ofs_out,
    input logic              sample_stb
);

    logic sync_prev_c;
    logic fall_c;

    // Independent record of the previously sampled line-sync level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_prev_c <= 1'b0;
        else        sync_prev_c <= line_sync;
    end

    assign fall_c = sync_prev_c & ~line_sync;

    p_mono_red_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg == CFG_MONO |=> (par_sel == CH_RED) && (in_sel == CH_RED));

    p_input_red_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg == CFG_PIX_PAR |=> in_sel == CH_RED);

    p_pix_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == CFG_PIX_ALL) && !line_sync && !fall_c
        |=> (par_sel == chan_next($past(par_sel))) && (in_sel == par_sel));

    p_sync_red_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg == CFG_PIX_PAR) || (cfg == CFG_PIX_ALL)) && line_sync |=> par_sel == CH_RED);

    p_stb_red_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (par_sel == CH_RED) && (in_sel == CH_RED));

    p_stb_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != CFG_PIX_ALL) || line_sync |=> !sample_stb);

    p_line_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == CFG_LINE) && !mode_wr && fall_c |=> par_sel == chan_next($past(par_sel)));

    p_line_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == CFG_LINE) && mode_wr |=> par_sel == CH_RED);

    p_line_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == CFG_LINE) && !mode_wr && !fall_c
        |=> $stable(par_sel) && $stable(in_sel) && $stable(gain_out) && $stable(ofs_out));

    p_index_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (par_sel != 2'd3) && (in_sel != 2'd3));

endmodule

bind chan_rot_seq chan_rot_seq_chk #(.GAIN_W(GAIN_W), .OFS_W(OFS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_sync  (line_sync),
    .cfg        (cfg),
    .mode_wr    (mode_wr),
    .in_sel     (in_sel),
    .par_sel    (par_sel),
    .gain_out   (gain_out),
    .ofs_out    (ofs_out),
    .sample_stb (sample_stb)
);

// File: tb/chan_rot_seq_tb.sv
// Bench: sweeps every configuration over whole lines. Expected channels come
// from the pixel or line count modulo three.
module chan_rot_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       line_sync;
    logic [1:0] cfg;
    logic       mode_wr;
    logic [5:0] gain_red, gain_grn, gain_blu;
    logic [7:0] ofs_red, ofs_grn, ofs_blu;
    logic [1:0] in_sel, par_sel;
    logic [5:0] gain_out;
    logic [7:0] ofs_out;
    logic       sample_stb;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    int gv [3];
    int ov [3];

    always #4 clk = ~clk;

    chan_rot_seq u_dut (
        .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .cfg(cfg), .mode_wr(mode_wr),
        .gain_red(gain_red), .gain_grn(gain_grn), .gain_blu(gain_blu),
        .ofs_red(ofs_red), .ofs_grn(ofs_grn), .ofs_blu(ofs_blu),
        .in_sel(in_sel), .par_sel(par_sel), .gain_out(gain_out), .ofs_out(ofs_out),
        .sample_stb(sample_stb)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic load_regs();
        gain_red = 6'(gv[0]); gain_grn = 6'(gv[1]); gain_blu = 6'(gv[2]);
        ofs_red  = 8'(ov[0]); ofs_grn  = 8'(ov[1]); ofs_blu  = 8'(ov[2]);
    endtask

    // Check the full output set against one channel.
    task automatic chk_chan(input string rq, input int par, input int inp, input int stb);
        chk(rq, "par_sel", par_sel, par);
        chk(rq, "in_sel", in_sel, inp);
        chk(rq, "gain_out", gain_out, gv[par]);
        chk(rq, "ofs_out", ofs_out, ov[par]);
        chk(rq, "sample_stb", sample_stb, stb);
    endtask

    // One line in a per-pixel scheme, with a mid-line sync pulse.
    task automatic run_pix(input logic [1:0] c);
        cfg = c;
        line_sync = 1'b1;
        step(); step();
        chk("R5", "par_sel in sync", par_sel, 0);
        chk("R6", "stb in sync", sample_stb, 0);
        line_sync = 1'b0;
        for (int k = 0; k < 9; k++) begin
            step();
            if (c == 2'b01) chk_chan("R3", k % 3, 0, 0);
            else            chk_chan("R4", k % 3, k % 3, (k % 3 == 0) ? 1 : 0);
        end
        line_sync = 1'b1;
        step();
        chk("R5", "par_sel mid sync", par_sel, 0);
        chk("R6", "stb mid sync", sample_stb, 0);
        line_sync = 1'b0;
        step();
        chk_chan("R5", 0, 0, (c == 2'b10) ? 1 : 0);
        step();
        chk_chan("R5", 1, (c == 2'b10) ? 1 : 0, 0);
    endtask

    // Per-line scheme: one line gap followed by the first low edge.
    task automatic line_pulse(input int exp_before, input int exp_after);
        line_sync = 1'b1;
        step();
        chk("R7", "par_sel sync high", par_sel, exp_before);
        line_sync = 1'b0;
        step();
        chk_chan("R7", exp_after, exp_after, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        gv[0] = 5;  gv[1] = 17; gv[2] = 42;
        ov[0] = 17; ov[1] = 90; ov[2] = 195;
        load_regs();
        rst_n = 1'b0; line_sync = 1'b0; cfg = 2'b00; mode_wr = 1'b0;
        step(); step(); step();
        chk("R1", "par_sel", par_sel, 0);
        chk("R1", "in_sel", in_sel, 0);
        chk("R1", "gain_out", gain_out, 0);
        chk("R1", "ofs_out", ofs_out, 0);
        chk("R1", "sample_stb", sample_stb, 0);
        rst_n = 1'b1;

        // R2: fixed red channel.
        for (int k = 0; k < 4; k++) begin
            step();
            chk_chan("R2", 0, 0, 0);
        end
        gv[0] = 9; load_regs();
        step();
        chk("R10", "gain_out reload", gain_out, 9);

        run_pix(2'b01);
        run_pix(2'b10);

        // Per-line scheme: restart then step through lines.
        cfg = 2'b11; mode_wr = 1'b1;
        step();
        mode_wr = 1'b0;
        chk_chan("R8", 0, 0, 0);
        for (int n = 1; n <= 5; n++) begin
            line_pulse((n - 1) % 3, n % 3);
            step(); step();
            chk_chan("R9", n % 3, n % 3, 0);
        end
        // Now on blue: a register change must not reach the outputs.
        gain_blu = 6'd50;
        step();
        chk("R9", "gain_out held", gain_out, 42);
        gv[2] = 50;
        // Write and line-sync fall together: write wins.
        line_sync = 1'b1;
        step();
        line_sync = 1'b0; mode_wr = 1'b1;
        step();
        mode_wr = 1'b0;
        chk_chan("R8", 0, 0, 0);
        line_pulse(0, 1);
        line_pulse(1, 2);
        chk("R10", "gain_out new blue", gain_out, 50);
        line_pulse(2, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule